// File: doc/BRIEF.md
# PWM Duty Cycle Meter

This block watches a pulse-width modulated input whose frequency drifts over time. For every period it measures how long the input stays high and how long it stays low, in system-clock cycles. From those two counts it derives the duty cycle as a fixed-point fraction and a signed figure equal to 2.2 times the duty cycle minus one half. No fixed period is assumed: both phases are counted again in every period, and the ratio is formed in hardware by a serial divider.

The input is asynchronous and is retimed by a short flip-flop chain before any counting. A period is closed at each rising edge of the retimed signal. The closed counts go to the divider, and the finished result is offered on a valid/ready output. The output register holds a single result. Back-pressure is absorbed by dropping whole periods, never by stalling the counters. A period that closes while the divider is still working, or while an earlier result has not been taken, is discarded, and a saturating overrun counter records the loss. A stuck input cannot make a count wrap around. The count stops at its maximum and a sticky timeout flag is raised.

Top module: `pwm_duty_meter`

## Requirements
- R1: `pwm_in` is retimed through SYNC_STAGES flip-flops. Every level held for N clock cycles adds exactly N to the count of that phase, N = 1 included.
- R2: A period runs from one rising edge of the retimed input to the next. `res_high` is the number of high cycles in the period and `res_low` is the number of low cycles. Both are at least 1 in any reported period.
- R3: The first rising edge after reset only starts counting. Nothing is reported for the time before it.
- R4: `res_duty` = floor((H*2^FRAC_W + floor((H+L)/2)) / (H+L)), with H and L the reported counts. It lies between 0 and 2^FRAC_W inclusive.
- R5: `res_value` = floor((GAIN*(res_duty - 2^(FRAC_W-1)) + 2^(GAIN_SH-1)) / 2^GAIN_SH), in two's complement, with GAIN = 563 and GAIN_SH = 8 by default. It is negative when `res_duty` is below 2^(FRAC_W-1) and positive when it is above.
- R6: While `res_valid` is 1 and `res_ready` is 0, `res_valid` and all result fields hold steady. After a cycle with both at 1, `res_valid` is 0.
- R7: A period is discarded if it closes while the divider is busy or while `res_valid` is 1. Each discarded period adds 1 to `overrun_cnt`, which saturates at 2^OVR_W-1.
- R8: A phase count stops at 2^CNT_W-1. Reaching that value sets `timeout`, which stays at 1 until reset. The saturated count is the one reported.
- R9: After reset, `res_valid`, `timeout` and `overrun_cnt` are 0.
- R10: Results come out in the order the accepted periods closed, one result per accepted period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Asynchronous PWM input |
| res_ready | input | 1 | Consumer can take the result |
| res_valid | output | 1 | Result registers hold an untaken result |
| res_high | output | CNT_W | High-phase cycle count of the period |
| res_low | output | CNT_W | Low-phase cycle count of the period |
| res_duty | output | FRAC_W+1 | Duty cycle scaled so that 2^FRAC_W is full duty |
| res_value | output | RES_W | Signed 2.2*(duty-0.5) in the same scale |
| timeout | output | 1 | Sticky flag: a phase count reached its ceiling |
| overrun_cnt | output | OVR_W | Saturating count of discarded periods |

## Verification
The bound checker watches, on every cycle, the behaviour that can be judged from the ports alone. It checks that a stalled result stays steady and that it is released after a handshake. It checks that the duty stays within range, that the result carries the right sign on each side of one half, that no reported period has an empty phase, that the timeout flag stays set, and that the overrun count never decreases. The exact cycle counts, the rounding of the quotient and of the gain stage, the arming at the first edge, which periods are dropped under back-pressure and while the divider is busy, and the saturation of both counters can only be shown by the bench's scenarios. There, a scoreboard predicts every result from the high and low times it drove.

// File: rtl/pwm_meter_pkg.sv
package pwm_meter_pkg;

  // Sequencing of the serial divider.
  typedef enum logic [1:0] {
    DV_IDLE,
    DV_RUN,
    DV_DONE
  } div_state_e;

  // Width of the signed gain-stage result for a given scale, gain and shift.
  function automatic int res_width(input int frac_w, input int gain, input int shift);
    return frac_w + 2 + $clog2(gain + 1) - shift;
  endfunction

endpackage

// File: rtl/pwm_sync_edge.sv
module pwm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_async,
  output logic level,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              level_d;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= pwm_async;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pwm_async};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~level_d;

endmodule

// File: rtl/pwm_phase_counter.sv
module pwm_phase_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             rise,
  output logic             per_stb,
  output logic [CNT_W-1:0] per_hi,
  output logic [CNT_W-1:0] per_lo,
  output logic             timeout
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_NEAR = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] hi_c;
  logic [CNT_W-1:0] lo_c;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_c    <= '0;
      lo_c    <= '0;
      armed   <= 1'b0;
      per_stb <= 1'b0;
      per_hi  <= '0;
      per_lo  <= '0;
      timeout <= 1'b0;
    end else begin
      per_stb <= 1'b0;
      if (rise) begin
        // Close the running period (only once a full one has been seen)
        if (armed) begin
          per_stb <= 1'b1;
          per_hi  <= hi_c;
          per_lo  <= lo_c;
        end
        armed <= 1'b1;
        hi_c  <= CNT_W'(1);
        lo_c  <= '0;
      end else if (level) begin
        if (hi_c != CNT_MAX) begin
          hi_c <= hi_c + CNT_W'(1);
          if (hi_c == CNT_NEAR) timeout <= 1'b1;
        end
      end else begin
        if (lo_c != CNT_MAX) begin
          lo_c <= lo_c + CNT_W'(1);
          if (lo_c == CNT_NEAR) timeout <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pwm_ratio_divider.sv
module pwm_ratio_divider
  import pwm_meter_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  hi_cnt,
  input  logic [CNT_W-1:0]  lo_cnt,
  output logic              busy,
  output logic              done,
  output logic [FRAC_W:0]   duty
);

  localparam int DVD_W  = CNT_W + FRAC_W + 1;
  localparam int DIV_W  = CNT_W + 1;
  localparam int REM_W  = CNT_W + 2;
  localparam int STEP_W = $clog2(DVD_W);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(DVD_W - 1);

  div_state_e        st;
  logic [DVD_W-1:0]  sr;
  logic [REM_W-1:0]  rem;
  logic [DIV_W-1:0]  dvs;
  logic [STEP_W-1:0] step;

  logic [DIV_W-1:0]  sum_w;
  logic [DVD_W-1:0]  dvd_w;
  logic [REM_W-1:0]  trial;
  logic              fits;

  always_comb begin
    sum_w = {1'b0, hi_cnt} + {1'b0, lo_cnt};
    // Numerator scaled to full duty, plus half the divisor for rounding
    dvd_w = DVD_W'({hi_cnt, {FRAC_W{1'b0}}}) + DVD_W'(sum_w >> 1);
    trial = {rem[REM_W-2:0], sr[DVD_W-1]};
    fits  = trial >= {1'b0, dvs};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= DV_IDLE;
      sr   <= '0;
      rem  <= '0;
      dvs  <= '0;
      step <= '0;
    end else begin
      case (st)
        DV_IDLE: begin
          if (start) begin
            sr   <= dvd_w;
            rem  <= '0;
            dvs  <= sum_w;
            step <= '0;
            st   <= DV_RUN;
          end
        end
        DV_RUN: begin
          rem <= fits ? (trial - {1'b0, dvs}) : trial;
          sr  <= {sr[DVD_W-2:0], fits};
          if (step == LAST_STEP) st <= DV_DONE;
          else                   step <= step + STEP_W'(1);
        end
        DV_DONE: st <= DV_IDLE;
        default: st <= DV_IDLE;
      endcase
    end
  end

  assign busy = (st != DV_IDLE);
  assign done = (st == DV_DONE);
  assign duty = sr[FRAC_W:0];

endmodule

// File: rtl/pwm_duty_meter.sv
module pwm_duty_meter
  import pwm_meter_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FRAC_W      = 16,
  parameter int GAIN        = 563,
  parameter int GAIN_SH     = 8,
  parameter int OVR_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int RES_W      = res_width(FRAC_W, GAIN, GAIN_SH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwm_in,
  input  logic                    res_ready,
  output logic                    res_valid,
  output logic [CNT_W-1:0]        res_high,
  output logic [CNT_W-1:0]        res_low,
  output logic [FRAC_W:0]         res_duty,
  output logic signed [RES_W-1:0] res_value,
  output logic                    timeout,
  output logic [OVR_W-1:0]        overrun_cnt
);

  localparam int GAIN_W = $clog2(GAIN + 1);
  localparam int PROD_W = FRAC_W + 2 + GAIN_W;
  localparam logic signed [FRAC_W+1:0] HALF  = {2'b01, {(FRAC_W-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] GAIN_S = PROD_W'(GAIN);
  localparam logic signed [PROD_W-1:0] ROUND  = PROD_W'(1) <<< (GAIN_SH - 1);
  localparam logic [OVR_W-1:0]         OVR_MAX = '1;

  logic             lvl, rise;
  logic             per_stb;
  logic [CNT_W-1:0] per_hi, per_lo;
  logic             div_busy, div_done;
  logic [FRAC_W:0]  div_duty;
  logic             accept, drop;
  logic [CNT_W-1:0] acc_hi, acc_lo;

  logic signed [FRAC_W+1:0] centred;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rounded;
  logic signed [RES_W-1:0]  value_w;

  pwm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_async(pwm_in),
    .level    (lvl),
    .rise     (rise)
  );

  pwm_phase_counter #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (lvl),
    .rise   (rise),
    .per_stb(per_stb),
    .per_hi (per_hi),
    .per_lo (per_lo),
    .timeout(timeout)
  );

  // One period in flight at most: divider free and output slot empty
  assign accept = per_stb & ~div_busy & ~res_valid;
  assign drop   = per_stb & ~accept;

  pwm_ratio_divider #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .hi_cnt(per_hi),
    .lo_cnt(per_lo),
    .busy  (div_busy),
    .done  (div_done),
    .duty  (div_duty)
  );

  // Gain stage: GAIN*(duty - half), rounded, arithmetic shift
  always_comb begin
    centred = $signed({1'b0, div_duty}) - HALF;
    prod    = PROD_W'(centred) * GAIN_S;
    rounded = prod + ROUND;
    value_w = RES_W'(rounded >>> GAIN_SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_hi      <= '0;
      acc_lo      <= '0;
      res_valid   <= 1'b0;
      res_high    <= '0;
      res_low     <= '0;
      res_duty    <= '0;
      res_value   <= '0;
      overrun_cnt <= '0;
    end else begin
      if (accept) begin
        acc_hi <= per_hi;
        acc_lo <= per_lo;
      end
      if (drop && overrun_cnt != OVR_MAX) overrun_cnt <= overrun_cnt + OVR_W'(1);
      if (div_done) begin
        res_valid <= 1'b1;
        res_high  <= acc_hi;
        res_low   <= acc_lo;
        res_duty  <= div_duty;
        res_value <= value_w;
      end else if (res_valid && res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwm_duty_meter_chk.sv
module pwm_duty_meter_chk #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 16,
  parameter int RES_W  = 20,
  parameter int OVR_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    res_ready,
  input logic                    res_valid,
  input logic [CNT_W-1:0]        res_high,
  input logic [CNT_W-1:0]        res_low,
  input logic [FRAC_W:0]         res_duty,
  input logic signed [RES_W-1:0] res_value,
  input logic                    timeout,
  input logic [OVR_W-1:0]        overrun_cnt
);

  localparam logic [FRAC_W:0] FULL = {1'b1, {FRAC_W{1'b0}}};
  localparam logic [FRAC_W:0] HALF = {2'b01, {(FRAC_W-1){1'b0}}};

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid);

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> $stable(res_high) && $stable(res_low)
                                && $stable(res_duty) && $stable(res_value));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !res_valid);

  p_duty_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_duty <= FULL);

  p_neg_below_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_duty < HALF |-> res_value < 0);

  p_pos_above_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_duty > HALF |-> res_value > 0);

  p_phases_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_high != '0 && res_low != '0);

  p_timeout_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> timeout);

  p_overrun_monotonic_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> overrun_cnt >= $past(overrun_cnt));

endmodule

bind pwm_duty_meter pwm_duty_meter_chk #(
  .CNT_W (CNT_W),
  .FRAC_W(FRAC_W),
  .RES_W (RES_W),
  .OVR_W (OVR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_ready  (res_ready),
  .res_valid  (res_valid),
  .res_high   (res_high),
  .res_low    (res_low),
  .res_duty   (res_duty),
  .res_value  (res_value),
  .timeout    (timeout),
  .overrun_cnt(overrun_cnt)
);

// File: tb/pwm_duty_meter_bench.sv
`timescale 1ns/1ps
module pwm_duty_meter_bench;

  localparam int CNT_W   = 10;
  localparam int FRAC_W  = 16;
  localparam int GAIN    = 563;
  localparam int GAIN_SH = 8;
  localparam int OVR_W   = 2;
  localparam int RES_W   = FRAC_W + 2 + $clog2(GAIN + 1) - GAIN_SH;
  localparam int CMAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n, pwm_in, res_ready;
  logic res_valid, timeout;
  logic [CNT_W-1:0] res_high, res_low;
  logic [FRAC_W:0] res_duty;
  logic signed [RES_W-1:0] res_value;
  logic [OVR_W-1:0] overrun_cnt;

  always #2.5 clk = ~clk;

  pwm_duty_meter #(
    .CNT_W(CNT_W), .FRAC_W(FRAC_W), .GAIN(GAIN), .GAIN_SH(GAIN_SH),
    .OVR_W(OVR_W), .SYNC_STAGES(2)
  ) u_pwm_duty_meter (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .res_ready(res_ready),
    .res_valid(res_valid), .res_high(res_high), .res_low(res_low),
    .res_duty(res_duty), .res_value(res_value), .timeout(timeout),
    .overrun_cnt(overrun_cnt)
  );

  typedef struct { int hi; int lo; } exp_t;
  exp_t exp_q[$];
  int total = 0, bad = 0, n_pushed = 0, n_seen = 0;
  bit finished = 0;

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_duty(longint h, longint l);
    return (h * (64'sd1 << FRAC_W) + (h + l) / 2) / (h + l);
  endfunction

  function automatic longint exp_value(longint d);
    longint p;
    p = GAIN * (d - (64'sd1 << (FRAC_W - 1))) + (64'sd1 << (GAIN_SH - 1));
    return p >>> GAIN_SH;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one period, pushes the expected item when it will be accepted
  task automatic pwm_period(int h, int l, bit push);
    exp_t e;
    pwm_in = 1'b1; cyc(h);
    pwm_in = 1'b0; cyc(l);
    if (push) begin
      e.hi = (h > CMAX) ? CMAX : h;
      e.lo = (l > CMAX) ? CMAX : l;
      exp_q.push_back(e);
      n_pushed++;
    end
  endtask

  // Monitor: compare every handshaken result against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && res_valid && res_ready) begin
      n_seen++;
      if (exp_q.size() == 0) begin
        chk("R10 unexpected result", 1, 0);
      end else begin
        exp_t e;
        longint d;
        e = exp_q.pop_front();
        d = exp_duty(e.hi, e.lo);
        chk("R1 high count", res_high, e.hi);
        chk("R2 low count", res_low, e.lo);
        chk("R4 duty", res_duty, d);
        chk("R5 value", res_value, exp_value(d));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CNT_W-1:0] s_hi;
    logic [FRAC_W:0]  s_duty;
    rst_n = 1'b0; pwm_in = 1'b0; res_ready = 1'b0;
    cyc(5);
    chk("R9 valid after reset", res_valid, 0);
    chk("R9 timeout after reset", timeout, 0);
    chk("R9 overrun after reset", overrun_cnt, 0);
    rst_n = 1'b1;
    res_ready = 1'b1;
    cyc(20);
    chk("R3 nothing before first edge", n_seen, 0);

    // Normal periods: each closed at the next call's rising edge
    pwm_period(20, 40, 1);
    chk("R3 first edge only arms", n_seen, 0);
    pwm_period(1, 60, 1);
    pwm_period(60, 1, 1);
    pwm_period(33, 33, 1);
    pwm_period(7, 93, 1);
    pwm_period(45, 15, 1);
    pwm_period(100, 3, 1);
    chk("R10 results so far", n_seen, 6);

    // Back-pressure: last normal result held, next three periods dropped
    res_ready = 1'b0;
    pwm_period(30, 50, 0);
    chk("R6 valid while stalled", res_valid, 1);
    s_hi = res_high; s_duty = res_duty;
    pwm_period(50, 30, 0);
    pwm_period(25, 55, 0);
    pwm_in = 1'b1; cyc(5);
    chk("R7 overrun after three drops", overrun_cnt, 3);
    chk("R6 high held", res_high, s_hi);
    chk("R6 duty held", res_duty, s_duty);
    chk("R6 valid still held", res_valid, 1);
    res_ready = 1'b1;
    cyc(35);
    pwm_in = 1'b0; cyc(40);
    exp_q.push_back('{hi: 40, lo: 40}); n_pushed++;
    chk("R6 released after handshake", res_valid, 0);

    // Period closing while divider busy is dropped; counter saturates
    pwm_period(5, 5, 0);
    pwm_period(60, 60, 1);
    chk("R7 overrun saturates", overrun_cnt, 3);
    chk("R8 no timeout yet", timeout, 0);

    // Stuck levels: both counts saturate
    pwm_in = 1'b1; cyc(1100);
    chk("R8 timeout on stuck high", timeout, 1);
    pwm_in = 1'b0; cyc(1200);
    exp_q.push_back('{hi: CMAX, lo: CMAX}); n_pushed++;
    pwm_period(10, 50, 1);
    pwm_in = 1'b1; cyc(60);
    pwm_in = 1'b0; cyc(60);
    chk("R8 timeout sticky", timeout, 1);
    chk("R10 all results seen", n_seen, n_pushed);
    chk("R10 scoreboard empty", exp_q.size(), 0);
    chk("R7 overrun final", overrun_cnt, 3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule